// File: doc/BRIEF.md
# Serial Memory Slave Front-End with Transfer Pause

This block is the wire-level slave side of a byte-organised serial memory. The serial clock is mode 0: it idles low, input data is taken on its rising edge and output data changes on its falling edge. A system clock oversamples the four serial pins through synchronisers. Incoming bits are gathered most significant bit first into bytes, and each byte is handed to a back-end with a one-cycle strobe. Outgoing bytes are taken from the back-end at each byte boundary and shifted out on the data output, along with an output-enable for the pad's tri-state driver.

A transfer is framed by an active-low select. A transfer is only accepted after select has been seen to fall. Deselecting at any point aborts the transfer. An active-low pause input can freeze a transfer mid-byte. While paused, input bits are ignored and the output driver is released, but the bit and byte position are kept, so the transfer resumes where it stopped. Pause changes count only while the serial clock is low.

The second and third bytes of every transfer are assembled into a word address. Its width is 14 or 15 bits, chosen by a parameter for a 16,384-word or 32,768-word array. Command decoding, the array and write timing belong to the back-end.

Top module: `spi_mem_frontend`

## Requirements
- R1: While `cs_n` is high, `so_oe` is 0, SCK edges on `sck` have no effect (no `rx_valid`), and the bit counter, byte counter, pause state and `addr_valid` are cleared; a deselect in mid-byte aborts that byte.
- R2: After reset, a falling edge of `cs_n` is needed before bits are accepted; if `cs_n` is already low when reset is released, no byte is received and `so_oe` stays 0 until `cs_n` has gone high and low again.
- R3: While selected and not paused, `si` is sampled on each rising edge of `sck`, most significant bit first; after every eighth bit `rx_byte` holds the byte and `rx_valid` is high for exactly one clock, and the bit count restarts at zero.
- R4: `so` changes only on falling edges of `sck`; on the first falling edge after a byte boundary `tx_byte` is loaded (bit 7 driven first) and `tx_load` pulses for one clock; each later falling edge shifts the next lower bit onto `so`.
- R5: Pausing starts when `hold_n` is low while `sck` is low; while paused `so_oe` is 0 and `sck` edges neither sample `si` nor move `so`.
- R6: Pausing ends when `hold_n` is high while `sck` is low; the bit and byte position are kept across the pause, so the byte in progress completes with its earlier bits intact.
- R7: A change of `hold_n` while `sck` is high has no effect until `sck` is next low; a low pulse on `hold_n` that starts and ends within one high phase of `sck` never pauses.
- R8: The second and third received bytes form a 16-bit value (second byte high); its low `AW` bits appear on `addr` and `addr_valid` rises with the third `rx_valid`; `AW` is 14 when `LARGE_ARRAY` is 0 and 15 when it is 1.
- R9: Each pin change takes effect on the third rising edge of `clk` after it (two synchroniser stages plus one edge-detect register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `sck` |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data input |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for `so` (0 means high impedance) |
| tx_byte | input | 8 | Next byte to send, supplied by the back-end |
| tx_load | output | 1 | One-cycle pulse when `tx_byte` has been taken |
| rx_byte | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_byte` |
| addr | output | AW | Word address from the second and third bytes |
| addr_valid | output | 1 | `addr` holds the current transfer's address |

## Verification
Every pin change shows up at the outputs on the third system clock edge after it. The bench therefore drives pins on falling clock edges and holds each serial clock phase for four system clocks. It reads `so_oe` and `so` only after such a phase has settled. For the latency check it samples `so_oe` after exactly two and then three edges. The `rx_valid` and `tx_load` strobes last one cycle, so a monitor counts them on falling clock edges. Each test compares the strobe counts and the last captured byte once its final serial phase has settled.

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
  parameter bit LARGE_ARRAY = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int WORDS = LARGE_ARRAY ? 32768 : 16384,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  input  logic [7:0]    tx_byte,
  output logic          tx_load,
  output logic [7:0]    rx_byte,
  output logic          rx_valid,
  output logic [AW-1:0] addr,
  output logic          addr_valid
);

  logic [SYNC_STAGES-1:0] cs_q, sck_q, hold_q, si_q;
  logic cs_d, sck_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q   <= '0;
      sck_q  <= '0;
      hold_q <= '1;
      si_q   <= '0;
      cs_d   <= 1'b0;
      sck_d  <= 1'b0;
    end else begin
      cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
      sck_q  <= {sck_q[SYNC_STAGES-2:0], sck};
      hold_q <= {hold_q[SYNC_STAGES-2:0], hold_n};
      si_q   <= {si_q[SYNC_STAGES-2:0], si};
      cs_d   <= cs_q[SYNC_STAGES-1];
      sck_d  <= sck_q[SYNC_STAGES-1];
    end

  wire cs_s     = cs_q[SYNC_STAGES-1];
  wire sck_s    = sck_q[SYNC_STAGES-1];
  wire hold_s   = hold_q[SYNC_STAGES-1];
  wire si_s     = si_q[SYNC_STAGES-1];
  wire cs_fall  = cs_d & ~cs_s;
  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;

  logic armed, held;
  wire active = armed & ~held & ~cs_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      held  <= 1'b0;
    end else if (cs_s) begin
      armed <= 1'b0;
      held  <= 1'b0;
    end else begin
      if (cs_fall) armed <= 1'b1;
      if (armed && !sck_s) held <= ~hold_s;
    end

  logic [2:0] bit_cnt;
  logic [1:0] byte_cnt;
  logic [6:0] rx_sh;
  logic [7:0] addr_hi;
  wire  [7:0]  rx_next = {rx_sh, si_s};
  wire  [15:0] addr_full = {addr_hi, rx_next};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt    <= '0;
      byte_cnt   <= '0;
      rx_sh      <= '0;
      rx_byte    <= '0;
      rx_valid   <= 1'b0;
      addr_hi    <= '0;
      addr       <= '0;
      addr_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (cs_s) begin
        bit_cnt    <= '0;
        byte_cnt   <= '0;
        addr_valid <= 1'b0;
      end else if (active && sck_rise) begin
        rx_sh   <= rx_next[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_byte  <= rx_next;
          rx_valid <= 1'b1;
          if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
          if (byte_cnt == 2'd1) addr_hi <= rx_next;
          if (byte_cnt == 2'd2) begin
            addr       <= addr_full[AW-1:0];
            addr_valid <= 1'b1;
          end
        end
      end
    end

  logic [7:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (cs_s) tx_sh <= '0;
      else if (active && sck_fall) begin
        if (bit_cnt == 3'd0) begin
          tx_sh   <= tx_byte;
          tx_load <= 1'b1;
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end

  assign so    = tx_sh[7];
  assign so_oe = active;

endmodule

// File: rtl/spi_mem_frontend_chk.sv
module spi_mem_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       cs_d,
  input logic       sck_s,
  input logic       armed,
  input logic       held,
  input logic [2:0] bit_cnt,
  input logic       rx_valid,
  input logic       so_oe,
  input logic       addr_valid
);

  p_deselect_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!so_oe && bit_cnt == 3'd0 && !held && !addr_valid));

  p_arm_needs_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(cs_d) && !$past(cs_s)));

  p_byte_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (bit_cnt == 3'd0));

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_hiz_paused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);

  p_pause_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_s) |=> $stable(bit_cnt));

  p_no_pause_change_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_s && !cs_s) |=> $stable(held));

  p_addr_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> rx_valid);

endmodule

bind spi_mem_frontend spi_mem_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_d(cs_d), .sck_s(sck_s),
  .armed(armed), .held(held), .bit_cnt(bit_cnt), .rx_valid(rx_valid),
  .so_oe(so_oe), .addr_valid(addr_valid)
);

// File: tb/test_spi_mem_frontend.sv
module test_spi_mem_frontend;
  localparam int CLK_PERIOD = 10;
  localparam int PH = 4;
  localparam int AW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic so, so_oe, tx_load, rx_valid, addr_valid;
  logic [7:0] rx_byte;
  logic [AW-1:0] addr;

  int checks = 0, fails = 0;
  int rx_cnt = 0, ld_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_mem_frontend i_spi_mem_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .tx_byte(tx_byte), .tx_load(tx_load),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .addr(addr), .addr_valid(addr_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end
    if (tx_load) ld_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic got);
    si = b;
    wclk(PH);
    got = so;
    sck = 1'b1;
    wclk(PH);
    sck = 1'b0;
    wclk(PH);
  endtask

  task automatic sbyte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) sbit(mo[i], mi[i]);
  endtask

  task automatic select();
    cs_n = 1'b0;
    wclk(PH);
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    wclk(PH);
  endtask

  task automatic t_reset_no_arm();
    logic [7:0] d;
    check(so_oe == 1'b0 && rx_valid == 1'b0 && tx_load == 1'b0, "R2 reset state", so_oe, 0);
    sbyte(8'hE7, d);
    check(rx_cnt == 0, "R2 no byte without CS fall", rx_cnt, 0);
    check(so_oe == 1'b0, "R2 SO hi-z without CS fall", so_oe, 0);
    deselect();
  endtask

  task automatic t_latency();
    cs_n = 1'b0;
    wclk(2);
    check(so_oe == 1'b0, "R9 not yet enabled after 2 edges", so_oe, 0);
    wclk(1);
    check(so_oe == 1'b1, "R9 enabled on 3rd edge", so_oe, 1);
    wclk(PH);
    deselect();
  endtask

  task automatic t_read_addr();
    logic [7:0] d;
    int l0, r0;
    l0 = ld_cnt; r0 = rx_cnt;
    tx_byte = 8'hA5;
    select();
    sbyte(8'h03, d);
    check(rx_last == 8'h03, "R3 command byte MSB first", rx_last, 8'h03);
    sbyte(8'hFF, d);
    check(addr_valid == 1'b0, "R8 no address after two bytes", addr_valid, 0);
    sbyte(8'h12, d);
    check(addr_valid == 1'b1 && addr == 14'h3F12, "R8 address low 14 bits", addr, 14'h3F12);
    tx_byte = 8'h3C;
    sbyte(8'h00, d);
    check(d == 8'hA5, "R4 first read byte", d, 8'hA5);
    sbyte(8'h00, d);
    check(d == 8'h3C, "R4 second read byte", d, 8'h3C);
    check(ld_cnt - l0 == 5, "R4 one load per byte boundary", ld_cnt - l0, 5);
    check(rx_cnt - r0 == 5, "R3 one strobe per byte", rx_cnt - r0, 5);
    deselect();
    check(addr_valid == 1'b0 && so_oe == 1'b0, "R1 deselect clears addr and SO", addr_valid, 0);
  endtask

  task automatic t_pause();
    logic [7:0] d;
    logic g;
    int r0;
    select();
    for (int i = 7; i >= 4; i--) sbit(8'hB6 >> i, g);
    r0 = rx_cnt;
    hold_n = 1'b0;
    wclk(PH);
    check(so_oe == 1'b0, "R5 paused SO hi-z", so_oe, 0);
    for (int i = 0; i < 6; i++) sbit(i[0], g);
    check(rx_cnt == r0, "R5 no sampling while paused", rx_cnt, r0);
    hold_n = 1'b1;
    wclk(PH);
    check(so_oe == 1'b1, "R6 resumed SO driven", so_oe, 1);
    for (int i = 3; i >= 0; i--) sbit(8'hB6 >> i, g);
    check(rx_cnt == r0 + 1 && rx_last == 8'hB6, "R6 byte kept across pause", rx_last, 8'hB6);
    deselect();
    d = 8'h00;
  endtask

  task automatic t_pause_sck_high();
    logic g;
    select();
    for (int i = 7; i >= 5; i--) sbit(8'h96 >> i, g);
    si = 1'b1; wclk(PH);
    sck = 1'b1; wclk(PH);
    hold_n = 1'b0; wclk(PH);
    hold_n = 1'b1; wclk(PH);
    check(so_oe == 1'b1, "R7 pulse during SCK high ignored", so_oe, 1);
    sck = 1'b0; wclk(PH);
    check(so_oe == 1'b1, "R7 no pause after SCK low", so_oe, 1);
    for (int i = 3; i >= 0; i--) sbit(8'h96 >> i, g);
    check(rx_last == 8'h96, "R7 byte intact", rx_last, 8'h96);
    si = 1'b1; wclk(PH);
    sck = 1'b1; wclk(PH);
    hold_n = 1'b0; wclk(PH);
    check(so_oe == 1'b1, "R7 pause deferred while SCK high", so_oe, 1);
    sck = 1'b0; wclk(PH);
    check(so_oe == 1'b0, "R7 pause taken once SCK low", so_oe, 0);
    hold_n = 1'b1; wclk(PH);
    for (int i = 6; i >= 0; i--) sbit(8'hC3 >> i, g);
    check(rx_last == 8'hC3, "R6 byte after deferred pause", rx_last, 8'hC3);
    deselect();
  endtask

  task automatic t_abort_and_ignore();
    logic [7:0] d;
    logic g;
    int r0;
    select();
    for (int i = 0; i < 5; i++) sbit(1'b1, g);
    deselect();
    check(so_oe == 1'b0, "R1 SO hi-z after abort", so_oe, 0);
    r0 = rx_cnt;
    sbyte(8'hFF, d);
    check(rx_cnt == r0, "R1 SCK ignored while deselected", rx_cnt, r0);
    select();
    sbyte(8'h5A, d);
    check(rx_cnt == r0 + 1 && rx_last == 8'h5A, "R1 counters cleared by abort", rx_last, 8'h5A);
    deselect();
  endtask

  initial begin
    cs_n = 1'b0;
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    t_reset_no_arm();
    t_latency();
    t_read_addr();
    t_pause();
    t_pause_sck_high();
    t_abort_and_ignore();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule